// File: doc/BRIEF.md
# Interrupt Vector Priority Arbiter

This block sits next to a processor core and decides which of 256 interrupt vectors is offered to it. It keeps three 256-bit vector sets: requests waiting to be taken, vectors currently in service, and one trigger-mode flag per vector (level or edge). Incoming requests set a waiting bit and record their trigger mode. The block raises an interrupt-pending line whenever the highest waiting vector is allowed past the current processor priority.

The processor priority is formed from a 4-bit task priority class given by the core and from the highest vector already in service. Only a waiting vector whose 16-vector class is strictly above that priority may be taken. The core takes a vector with an acknowledge strobe and gets its number back one cycle later. When the best waiting vector is held back, the response is a configurable spurious vector and the request stays queued. A single-cycle end-of-interrupt strobe retires the highest vector in service. For a level-triggered vector, it also emits a broadcast that names the retired vector, unless directed end-of-interrupt is configured.

A 10-bit control word holds the spurious vector, a software enable and the directed-EOI switch.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset all three vector sets are empty and the control word is 0x0FF (bits [7:0] spurious vector 0xFF, bit 8 enable = 0, bit 9 directed-EOI = 0). In that state irq_pending, ack_valid and eoi_bcast are 0 and proc_prio is 0x00.
- R2: A cycle with req_valid high marks req_vector as waiting. It also stores req_level as that vector's trigger mode (1 = level, 0 = edge). A later request to the same vector overwrites the stored mode.
- R3: Of all waiting vectors, the one with the highest number is the candidate. With no vector waiting, an enabled acknowledge returns kind NONE.
- R4: proc_prio equals {task_class, 4'h0} when task_class is greater than or equal to bits [7:4] of the highest in-service vector. Otherwise it equals {those bits, 4'h0}. With nothing in service the in-service class counts as 0.
- R5: The candidate is blocked when proc_prio is nonzero and candidate[7:4] <= proc_prio[7:4]. When proc_prio is 0, every candidate is accepted, class 0 included.
- R6: While the enable bit (control bit 8) is 0, irq_pending stays 0 and an acknowledge returns kind NONE (ack_kind 2'b00, ack_vector 0x00). Requests are still recorded.
- R7: Acknowledging a blocked candidate returns kind SPURIOUS (ack_kind 2'b10) with ack_vector equal to control bits [7:0]. The candidate stays waiting.
- R8: Acknowledging an accepted candidate returns kind VECTOR (ack_kind 2'b01) with the vector number. The vector's waiting bit is cleared and its in-service bit is set.
- R9: An eoi strobe clears the highest-numbered in-service vector. If that vector's trigger mode is level and control bit 9 is 0, eoi_bcast pulses for one cycle with eoi_bcast_vector equal to the retired vector.
- R10: An eoi strobe with no vector in service changes nothing: there is no broadcast and proc_prio is unchanged.
- R11: ack_valid and eoi_bcast are single-cycle pulses in the cycle after the strobe. irq_pending is registered and reflects the vector sets one cycle after they change.
- R12: No broadcast is produced when the retired vector is edge-triggered, or when directed-EOI (control bit 9) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Vector being requested |
| req_level | input | 1 | Trigger mode of the request, 1 = level |
| task_class | input | 4 | Task priority class from the core |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_data | input | 10 | Control word: [7:0] spurious vector, [8] enable, [9] directed-EOI |
| ack_req | input | 1 | Acknowledge strobe from the core |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_pending | output | 1 | An acceptable vector is waiting |
| proc_prio | output | 8 | Current processor priority |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_kind | output | 2 | 00 none, 01 vector, 10 spurious |
| ack_vector | output | 8 | Returned vector |
| eoi_bcast | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector named by the broadcast |

## Verification
The ack and eoi responses are registered at the edge that takes the strobe, so the bench drives each strobe on a falling edge and reads the response on the next falling edge. irq_pending is computed from the vector sets at the edge after they change, so it is read two falling edges after the stimulus that alters them, and the bench also checks that it has not yet moved one falling edge earlier. proc_prio is combinational over the in-service set and task_class, so it is read at the falling edge right after an ack or eoi, or one cycle after task_class changes.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int VEC_W     = 8;
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int CLASS_W   = 4;
    localparam int SUB_W     = VEC_W - CLASS_W;
    localparam int CTRL_W    = VEC_W + 2;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [CLASS_W-1:0] class_t;
    typedef logic [NUM_VEC-1:0] vset_t;

    typedef enum logic [1:0] {
        ACK_NONE     = 2'b00,
        ACK_VECTOR   = 2'b01,
        ACK_SPURIOUS = 2'b10
    } ack_kind_e;

    typedef struct packed {
        logic directed_eoi;
        logic sw_enable;
        vec_t spur_vec;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{directed_eoi: 1'b0, sw_enable: 1'b0, spur_vec: '1};

    function automatic vset_t vec_onehot(input logic en, input vec_t v);
        vset_t r;
        r = '0;
        if (en) r[v] = 1'b1;
        return r;
    endfunction

    function automatic class_t class_of(input vec_t v);
        return v[VEC_W-1 -: CLASS_W];
    endfunction

    function automatic vec_t class_base(input class_t c);
        return {c, {SUB_W{1'b0}}};
    endfunction

endpackage

// File: rtl/prio_msb_find.sv
module prio_msb_find #(
    parameter int WORDS = 8,
    parameter int WW    = 32,
    parameter int IW    = 8
) (
    input  logic [WORDS*WW-1:0] bits,
    output logic                found,
    output logic [IW-1:0]       idx
);
    localparam int WIW    = $clog2(WW);
    localparam int WSEL_W = IW - WIW;

    logic [WORDS-1:0]     word_any;
    logic [WORDS*WIW-1:0] word_pos;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WW-1:0]  slice;
        logic [WIW-1:0] pos;
        assign slice = bits[w*WW +: WW];
        assign word_any[w] = |slice;
        always_comb begin
            pos = '0;
            for (int b = 0; b < WW; b++) begin
                if (slice[b]) pos = WIW'(b);
            end
        end
        assign word_pos[w*WIW +: WIW] = pos;
    end

    // Higher words override lower ones: last hit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_any[w]) begin
                found = 1'b1;
                idx   = {WSEL_W'(w), word_pos[w*WIW +: WIW]};
            end
        end
    end

endmodule

// File: rtl/prio_ppr_calc.sv
module prio_ppr_calc
    import irq_prio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  class_t task_class,
    input  logic   isr_found,
    input  vec_t   isr_top,
    input  vec_t   irr_top,
    output vec_t   ppr,
    output logic   req_blocked
);
    class_t svc_class;

    always_comb begin
        svc_class = isr_found ? class_of(isr_top) : '0;
        if (task_class >= svc_class) ppr = class_base(task_class);
        else                         ppr = class_base(svc_class);
        req_blocked = (ppr != '0) && (class_of(irr_top) <= class_of(ppr));
    end

    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (class_of(ppr) >= task_class) && (!isr_found || class_of(ppr) >= class_of(isr_top))); // R4

    AST_ZERO_PPR_OPEN: assert property (@(posedge clk) disable iff (rst)
        (ppr == '0) |-> !req_blocked); // R5

endmodule

// File: rtl/prio_vec_regs.sv
module prio_vec_regs
    import irq_prio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_en,
    input  vec_t  set_vec,
    input  logic  set_level,
    input  logic  take_en,
    input  vec_t  take_vec,
    input  logic  retire_en,
    input  vec_t  retire_vec,
    output vset_t irr,
    output vset_t isr,
    output vset_t tmr
);
    vset_t set_oh, take_oh, retire_oh;

    always_comb begin
        set_oh    = vec_onehot(set_en, set_vec);
        take_oh   = vec_onehot(take_en, take_vec);
        retire_oh = vec_onehot(retire_en, retire_vec);
    end

    // A new request wins over a take of the same vector; a take wins over a retire.
    always_ff @(posedge clk) begin
        if (rst) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= (irr & ~take_oh) | set_oh;
            isr <= (isr & ~retire_oh) | take_oh;
            if (set_en) tmr[set_vec] <= set_level;
        end
    end

    AST_TAKE_MOVES_BIT: assert property (@(posedge clk) disable iff (rst)
        (take_en && !(set_en && set_vec == take_vec)) |=>
        (isr[$past(take_vec)] && !irr[$past(take_vec)])); // R8

    AST_SET_MARKS_WAIT: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (irr[$past(set_vec)] && tmr[$past(set_vec)] == $past(set_level))); // R2

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    input  logic [CLASS_W-1:0] task_class,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_data,
    input  logic              ack_req,
    input  logic              eoi,
    output logic              irq_pending,
    output logic [VEC_W-1:0]  proc_prio,
    output logic              ack_valid,
    output logic [1:0]        ack_kind,
    output logic [VEC_W-1:0]  ack_vector,
    output logic              eoi_bcast,
    output logic [VEC_W-1:0]  eoi_bcast_vector
);
    ctrl_t     ctrl_q;
    vset_t     irr, isr, tmr;
    logic      irr_found, isr_found;
    vec_t      irr_top, isr_top;
    vec_t      ppr;
    logic      req_blocked;
    logic      take_en, retire_en;
    ack_kind_e nxt_kind;
    vec_t      nxt_vec;

    prio_vec_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .set_en     (req_valid),
        .set_vec    (req_vector),
        .set_level  (req_level),
        .take_en    (take_en),
        .take_vec   (irr_top),
        .retire_en  (retire_en),
        .retire_vec (isr_top),
        .irr        (irr),
        .isr        (isr),
        .tmr        (tmr)
    );

    prio_msb_find #(.WORDS(NUM_WORDS), .WW(WORD_W), .IW(VEC_W)) u_irr_find (
        .bits  (irr),
        .found (irr_found),
        .idx   (irr_top)
    );

    prio_msb_find #(.WORDS(NUM_WORDS), .WW(WORD_W), .IW(VEC_W)) u_isr_find (
        .bits  (isr),
        .found (isr_found),
        .idx   (isr_top)
    );

    prio_ppr_calc u_ppr (
        .clk         (clk),
        .rst         (rst),
        .task_class  (task_class),
        .isr_found   (isr_found),
        .isr_top     (isr_top),
        .irr_top     (irr_top),
        .ppr         (ppr),
        .req_blocked (req_blocked)
    );

    assign proc_prio = ppr;
    assign retire_en = eoi && isr_found;

    always_comb begin
        take_en  = 1'b0;
        nxt_kind = ACK_NONE;
        nxt_vec  = '0;
        if (ack_req && ctrl_q.sw_enable && irr_found) begin
            if (req_blocked) begin
                nxt_kind = ACK_SPURIOUS;
                nxt_vec  = ctrl_q.spur_vec;
            end else begin
                nxt_kind = ACK_VECTOR;
                nxt_vec  = irr_top;
                take_en  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q           <= CTRL_RESET;
            irq_pending      <= 1'b0;
            ack_valid        <= 1'b0;
            ack_kind         <= ACK_NONE;
            ack_vector       <= '0;
            eoi_bcast        <= 1'b0;
            eoi_bcast_vector <= '0;
        end else begin
            if (cfg_wr) ctrl_q <= ctrl_t'(cfg_data);
            irq_pending <= ctrl_q.sw_enable && irr_found && !req_blocked;
            ack_valid   <= ack_req;
            if (ack_req) begin
                ack_kind   <= nxt_kind;
                ack_vector <= nxt_vec;
            end
            eoi_bcast <= retire_en && tmr[isr_top] && !ctrl_q.directed_eoi;
            if (retire_en) eoi_bcast_vector <= isr_top;
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.sw_enable |=> !irq_pending); // R6

    AST_DISABLED_ACK_NONE: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !ctrl_q.sw_enable) |=> (ack_valid && ack_kind == ACK_NONE && ack_vector == '0)); // R6

    AST_SPUR_KEEPS_WAIT: assert property (@(posedge clk) disable iff (rst)
        (ack_req && ctrl_q.sw_enable && irr_found && req_blocked) |=>
        (ack_kind == ACK_SPURIOUS && irr_found)); // R7

    AST_EOI_EMPTY_NOP: assert property (@(posedge clk) disable iff (rst)
        (eoi && !isr_found) |=> (!eoi_bcast && !isr_found)); // R10

    AST_DIRECTED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (eoi && ctrl_q.directed_eoi) |=> !eoi_bcast); // R12

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        !ack_req |=> !ack_valid); // R11

endmodule

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [7:0] req_vector;
    logic       req_level;
    logic [3:0] task_class;
    logic       cfg_wr;
    logic [9:0] cfg_data;
    logic       ack_req;
    logic       eoi;
    logic       irq_pending;
    logic [7:0] proc_prio;
    logic       ack_valid;
    logic [1:0] ack_kind;
    logic [7:0] ack_vector;
    logic       eoi_bcast;
    logic [7:0] eoi_bcast_vector;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam int K_NONE = 0;
    localparam int K_VEC  = 1;
    localparam int K_SPUR = 2;

    always #5 clk = ~clk;

    irq_prio_arbiter i_irq_prio_arbiter (
        .clk              (clk),
        .rst              (rst),
        .req_valid        (req_valid),
        .req_vector       (req_vector),
        .req_level        (req_level),
        .task_class       (task_class),
        .cfg_wr           (cfg_wr),
        .cfg_data         (cfg_data),
        .ack_req          (ack_req),
        .eoi              (eoi),
        .irq_pending      (irq_pending),
        .proc_prio        (proc_prio),
        .ack_valid        (ack_valid),
        .ack_kind         (ack_kind),
        .ack_vector       (ack_vector),
        .eoi_bcast        (eoi_bcast),
        .eoi_bcast_vector (eoi_bcast_vector)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; req_vector = '0; req_level = 1'b0;
        task_class = '0; cfg_wr = 1'b0; cfg_data = '0; ack_req = 1'b0; eoi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [9:0] d);
        cfg_wr = 1'b1; cfg_data = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic raise(input logic [7:0] v, input logic lvl);
        req_valid = 1'b1; req_vector = v; req_level = lvl;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic take(input string req, input int exp_kind, input int exp_vec);
        ack_req = 1'b1;
        tick();
        ack_req = 1'b0;
        chk(req, "ack_valid", int'(ack_valid), 1);
        chk(req, "ack_kind", int'(ack_kind), exp_kind);
        chk(req, "ack_vector", int'(ack_vector), exp_vec);
    endtask

    task automatic retire(input string req, input int exp_b, input int exp_vec);
        eoi = 1'b1;
        tick();
        eoi = 1'b0;
        chk(req, "eoi_bcast", int'(eoi_bcast), exp_b);
        if (exp_b != 0) chk(req, "eoi_bcast_vector", int'(eoi_bcast_vector), exp_vec);
    endtask

    task automatic t_reset();
        do_reset();
        tick();
        chk("R1", "irq_pending after reset", int'(irq_pending), 0);
        chk("R1", "proc_prio after reset", int'(proc_prio), 0);
        chk("R1", "ack_valid after reset", int'(ack_valid), 0);
        chk("R1", "eoi_bcast after reset", int'(eoi_bcast), 0);
        raise(8'h40, 1'b0);
        tick();
        chk("R1", "disabled at reset keeps irq_pending low", int'(irq_pending), 0);
        take("R1", K_NONE, 0);
    endtask

    task automatic t_disabled();
        do_reset();
        raise(8'h80, 1'b0);
        tick();
        chk("R6", "irq_pending while disabled", int'(irq_pending), 0);
        take("R6", K_NONE, 0);
        write_cfg(10'h1FF);
        tick(); tick();
        chk("R6", "request kept while disabled", int'(irq_pending), 1);
        take("R6", K_VEC, 8'h80);
        write_cfg(10'h0FF);
        raise(8'hA0, 1'b0);
        take("R6", K_NONE, 0);
    endtask

    task automatic t_order();
        do_reset();
        write_cfg(10'h1F0);
        raise(8'h31, 1'b0);
        raise(8'h52, 1'b0);
        raise(8'h45, 1'b0);
        tick();
        chk("R3", "irq_pending with waiting vectors", int'(irq_pending), 1);
        take("R3", K_VEC, 8'h52);
        chk("R8", "proc_prio after taking 0x52", int'(proc_prio), 8'h50);
        tick(); tick();
        chk("R5", "class 4 blocked under 0x50", int'(irq_pending), 0);
        take("R7", K_SPUR, 8'hF0);
        retire("R12", 0, 0);
        chk("R9", "proc_prio after retire", int'(proc_prio), 0);
        take("R7", K_VEC, 8'h45);
        take("R7", K_SPUR, 8'hF0);
        retire("R9", 0, 0);
        take("R3", K_VEC, 8'h31);
        retire("R9", 0, 0);
        take("R3", K_NONE, 0);
    endtask

    task automatic t_ppr();
        do_reset();
        write_cfg(10'h1F0);
        task_class = 4'd5;
        raise(8'h5A, 1'b0);
        tick();
        chk("R4", "proc_prio from task class", int'(proc_prio), 8'h50);
        chk("R5", "equal class blocked", int'(irq_pending), 0);
        take("R7", K_SPUR, 8'hF0);
        raise(8'h61, 1'b0);
        tick();
        chk("R5", "higher class accepted", int'(irq_pending), 1);
        take("R8", K_VEC, 8'h61);
        chk("R4", "in-service class above task class", int'(proc_prio), 8'h60);
        task_class = 4'd7;
        tick();
        chk("R4", "task class above in-service", int'(proc_prio), 8'h70);
        task_class = 4'd0;
        retire("R9", 0, 0);
        chk("R4", "proc_prio back to zero", int'(proc_prio), 0);
        take("R5", K_VEC, 8'h5A);
        retire("R9", 0, 0);
        raise(8'h05, 1'b0);
        take("R5", K_VEC, 8'h05);
        retire("R9", 0, 0);
    endtask

    task automatic t_eoi();
        do_reset();
        write_cfg(10'h1FF);
        raise(8'h40, 1'b1);
        take("R8", K_VEC, 8'h40);
        raise(8'h90, 1'b0);
        take("R8", K_VEC, 8'h90);
        chk("R4", "nested proc_prio", int'(proc_prio), 8'h90);
        retire("R12", 0, 0);
        chk("R9", "highest in-service retired first", int'(proc_prio), 8'h40);
        retire("R9", 1, 8'h40);
        tick();
        chk("R11", "broadcast lasts one cycle", int'(eoi_bcast), 0);
        retire("R10", 0, 0);
        chk("R10", "proc_prio unchanged by empty eoi", int'(proc_prio), 0);
        raise(8'h70, 1'b1);
        raise(8'h70, 1'b0);
        take("R2", K_VEC, 8'h70);
        retire("R2", 0, 0);
        raise(8'h70, 1'b1);
        take("R2", K_VEC, 8'h70);
        retire("R2", 1, 8'h70);
        write_cfg(10'h3FF);
        raise(8'h70, 1'b1);
        take("R12", K_VEC, 8'h70);
        retire("R12", 0, 0);
        chk("R12", "directed retire still clears", int'(proc_prio), 0);
    endtask

    task automatic t_timing();
        do_reset();
        write_cfg(10'h1F0);
        raise(8'h22, 1'b0);
        chk("R11", "irq_pending not yet raised", int'(irq_pending), 0);
        tick();
        chk("R11", "irq_pending one cycle later", int'(irq_pending), 1);
        take("R11", K_VEC, 8'h22);
        chk("R11", "irq_pending before update", int'(irq_pending), 1);
        tick();
        chk("R11", "ack_valid single pulse", int'(ack_valid), 0);
        chk("R11", "irq_pending dropped", int'(irq_pending), 0);
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_disabled();
        t_order();
        t_ppr();
        t_eoi();
        t_timing();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule